// File: doc/BRIEF.md
# Thermally Assisted Cell Write Sequencer

This block writes one bit into one magnetic storage cell out of a small group that share a single write line. The write runs as a fixed timed sequence. First the addressed cell's heating select is raised. Then, with heating still on, the shared write-line current is enabled, and the direction of that current carries the data value. Heating is then removed while the current keeps flowing, so the cell cools under the field. Last, the current is released and a one-cycle completion pulse is given.

Only the cell whose heating select is active while the line current flows gets written. The cell's two storage elements sit on a folded line, so one current pulse stores the bit and its complement together.

A requester holds `wr_req` with an address and a data bit until it sees a one-cycle `wr_ack`. It then waits for `wr_done`. The length of each phase is a parameter in clock cycles. An elaboration-time check refuses any setting whose heat, field and cool phases together run longer than a 35 ns budget at the stated clock period, or that has a zero-length phase.

Top module: `twr_write_seq`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it rises with no request, `heat_sel`, `field_en`, `field_dir`, `wr_ack` and `wr_done` are all 0.
- R2: An accepted in-range write produces these phases in strict order. First, heating alone for HEAT_CYC cycles. Second, heating with `field_en` high for FIELD_CYC cycles. Third, `field_en` alone for COOL_CYC cycles. Fourth, one cycle with both off and `wr_done` high. In the `wr_done` cycle, neither heating nor current is active.
- R3: `field_dir` equals the data bit of the last accepted in-range write: 1 selects the current direction that stores a one, and 0 selects the opposite direction. It changes only in the cycle after acceptance, while `field_en` is low, so it is set at least HEAT_CYC cycles before `field_en` rises. It holds steady for as long as `field_en` is high.
- R4: Bit i of `heat_sel` is high only while cell i is the addressed cell of the write in progress. At most one bit of `heat_sel` is high at any time.
- R5: `field_en` never rises unless a heating select is already high in that same cycle.
- R6: `wr_ack` is a one-cycle pulse in the cycle after `wr_req` is sampled high while the block is idle. A request that is raised or held while a write is in progress is not acknowledged until after that write's `wr_done` pulse.
- R7: Every acknowledged request is followed by exactly one one-cycle `wr_done` pulse. `field_en` falls exactly when `wr_done` rises.
- R8: A request whose address is NUM_CELLS or more is acknowledged, and `wr_done` follows in the next cycle. No heating select goes high, `field_en` stays low, and `field_dir` keeps its previous value.
- R9: Elaboration fails unless HEAT_CYC, FIELD_CYC and COOL_CYC are each at least 1, and (HEAT_CYC+FIELD_CYC+COOL_CYC)×CLK_PERIOD_PS is no more than BUDGET_PS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_req | input | 1 | Write request, held until acknowledged |
| wr_addr | input | ADDR_W | Index of the cell to write |
| wr_data | input | 1 | Bit to store |
| wr_ack | output | 1 | One-cycle acknowledge of an accepted request |
| heat_sel | output | NUM_CELLS | Per-cell heating select, at most one high |
| field_en | output | 1 | Write-line current enable |
| field_dir | output | 1 | Write-line current direction, 1 stores a one |
| wr_done | output | 1 | One-cycle pulse when the field has been released |

## Verification
The bench goes after the following corner cases:

- **Phase boundaries.** A design that overlaps cooling with heating, or drops the field before heating ends, would write a cell that was not fully heated, or leave it unfixed. The per-cycle reference model catches this at the phase edges.
- **Back-to-back requests.** The bench holds a second request high straight after an acknowledge. A block that acknowledges while busy, or that restarts before `wr_done`, would abandon a write partway through.
- **Out-of-range addresses.** A wrong design would heat a nonexistent cell, alias onto a real one, or corrupt the direction register.
- **Direction changes between writes.** Opposite data values on consecutive writes show whether `field_dir` ever moves while current flows. If it did, one cell would take a mixed polarity.

// File: rtl/twr_pkg.sv
package twr_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_HEAT  = 3'd1,
    PH_FIELD = 3'd2,
    PH_COOL  = 3'd3,
    PH_DONE  = 3'd4
  } twr_phase_e;

  // Total heated-plus-field span of one write, in picoseconds.
  function automatic int unsigned seq_span_ps(input int unsigned heat_cyc,
                                              input int unsigned field_cyc,
                                              input int unsigned cool_cyc,
                                              input int unsigned period_ps);
    return (heat_cyc + field_cyc + cool_cyc) * period_ps;
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Counter width able to hold values 0 .. max_val.
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/twr_phase_timer.sv
module twr_phase_timer #(
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expire
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
    end else if (load) begin
      remain_q <= load_val;
    end else if (remain_q != '0) begin
      remain_q <= remain_q - 1'b1;
    end
  end

  assign expire = (remain_q == '0);

endmodule

// File: rtl/twr_heat_dec.sv
module twr_heat_dec #(
  parameter int unsigned NUM_CELLS = 6,
  parameter int unsigned ADDR_W    = 3
) (
  input  logic                 heat_on,
  input  logic [ADDR_W-1:0]    cell_addr,
  output logic [NUM_CELLS-1:0] sel
);

  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_cell
    assign sel[i] = heat_on && (cell_addr == ADDR_W'(i));
  end

endmodule

// File: rtl/twr_seq_ctrl.sv
module twr_seq_ctrl
  import twr_pkg::*;
#(
  parameter int unsigned NUM_CELLS = 6,
  parameter int unsigned ADDR_W    = 3,
  parameter int unsigned HEAT_CYC  = 1,
  parameter int unsigned FIELD_CYC = 1,
  parameter int unsigned COOL_CYC  = 2,
  parameter int unsigned CNT_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic [ADDR_W-1:0] addr,
  input  logic              data,
  input  logic              phase_expire,
  output logic              timer_load,
  output logic [CNT_W-1:0]  timer_val,
  output logic              ack,
  output logic [ADDR_W-1:0] cell_addr,
  output logic              dir,
  output logic              heat_on,
  output logic              field_on,
  output logic              done,
  output logic              busy
);

  localparam logic [CNT_W-1:0] HEAT_LAST  = CNT_W'(HEAT_CYC - 1);
  localparam logic [CNT_W-1:0] FIELD_LAST = CNT_W'(FIELD_CYC - 1);
  localparam logic [CNT_W-1:0] COOL_LAST  = CNT_W'(COOL_CYC - 1);

  twr_phase_e        phase_q, phase_d;
  logic              ack_q;
  logic [ADDR_W-1:0] addr_q;
  logic              dir_q;
  logic              accept;
  logic              addr_ok;

  assign addr_ok = (int'(addr) < int'(NUM_CELLS));
  assign accept  = (phase_q == PH_IDLE) && req;

  always_comb begin
    phase_d    = phase_q;
    timer_load = 1'b0;
    timer_val  = '0;
    unique case (phase_q)
      PH_IDLE: begin
        if (req) begin
          if (addr_ok) begin
            phase_d    = PH_HEAT;
            timer_load = 1'b1;
            timer_val  = HEAT_LAST;
          end else begin
            phase_d = PH_DONE;
          end
        end
      end
      PH_HEAT: begin
        if (phase_expire) begin
          phase_d    = PH_FIELD;
          timer_load = 1'b1;
          timer_val  = FIELD_LAST;
        end
      end
      PH_FIELD: begin
        if (phase_expire) begin
          phase_d    = PH_COOL;
          timer_load = 1'b1;
          timer_val  = COOL_LAST;
        end
      end
      PH_COOL: begin
        if (phase_expire) phase_d = PH_DONE;
      end
      PH_DONE: phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      ack_q   <= 1'b0;
      addr_q  <= '0;
      dir_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      ack_q   <= accept;
      if (accept && addr_ok) begin
        addr_q <= addr;
        dir_q  <= data;
      end
    end
  end

  assign ack       = ack_q;
  assign cell_addr = addr_q;
  assign dir       = dir_q;
  assign heat_on   = (phase_q == PH_HEAT)  || (phase_q == PH_FIELD);
  assign field_on  = (phase_q == PH_FIELD) || (phase_q == PH_COOL);
  assign done      = (phase_q == PH_DONE);
  assign busy      = (phase_q != PH_IDLE);

endmodule

// File: rtl/twr_write_seq.sv
module twr_write_seq
  import twr_pkg::*;
#(
  parameter int unsigned NUM_CELLS     = 6,
  parameter int unsigned HEAT_CYC      = 1,
  parameter int unsigned FIELD_CYC     = 1,
  parameter int unsigned COOL_CYC      = 2,
  parameter int unsigned CLK_PERIOD_PS = 8000,
  parameter int unsigned BUDGET_PS     = 35000,
  localparam int unsigned ADDR_W       = (NUM_CELLS > 1) ? $clog2(NUM_CELLS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_req,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic                 wr_data,
  output logic                 wr_ack,
  output logic [NUM_CELLS-1:0] heat_sel,
  output logic                 field_en,
  output logic                 field_dir,
  output logic                 wr_done
);

  localparam int unsigned SPAN_PS = seq_span_ps(HEAT_CYC, FIELD_CYC, COOL_CYC, CLK_PERIOD_PS);
  localparam int unsigned MAX_CYC = max3(HEAT_CYC, FIELD_CYC, COOL_CYC);
  localparam int unsigned CNT_W   = cnt_width(MAX_CYC);

  // R9: static timing budget and minimum phase length
  if (HEAT_CYC < 1 || FIELD_CYC < 1 || COOL_CYC < 1 || SPAN_PS > BUDGET_PS) begin : g_budget_fail
    $error("twr_write_seq: phase settings exceed the heated write budget");
  end

  logic              timer_load;
  logic [CNT_W-1:0]  timer_val;
  logic              phase_expire;
  logic [ADDR_W-1:0] cell_addr;
  logic              heat_on;
  logic              field_on;
  logic              busy;

  twr_phase_timer #(.CNT_W(CNT_W)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .expire   (phase_expire)
  );

  twr_seq_ctrl #(
    .NUM_CELLS (NUM_CELLS),
    .ADDR_W    (ADDR_W),
    .HEAT_CYC  (HEAT_CYC),
    .FIELD_CYC (FIELD_CYC),
    .COOL_CYC  (COOL_CYC),
    .CNT_W     (CNT_W)
  ) ctrl_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (wr_req),
    .addr         (wr_addr),
    .data         (wr_data),
    .phase_expire (phase_expire),
    .timer_load   (timer_load),
    .timer_val    (timer_val),
    .ack          (wr_ack),
    .cell_addr    (cell_addr),
    .dir          (field_dir),
    .heat_on      (heat_on),
    .field_on     (field_on),
    .done         (wr_done),
    .busy         (busy)
  );

  twr_heat_dec #(.NUM_CELLS(NUM_CELLS), .ADDR_W(ADDR_W)) heat_i (
    .heat_on   (heat_on),
    .cell_addr (cell_addr),
    .sel       (heat_sel)
  );

  assign field_en = field_on;

endmodule

// File: rtl/twr_write_seq_chk.sv
module twr_write_seq_chk #(
  parameter int unsigned NUM_CELLS = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CELLS-1:0] heat_sel,
  input logic                 field_en,
  input logic                 field_dir,
  input logic                 wr_ack,
  input logic                 wr_done,
  input logic                 busy
);

  logic heat_any;
  assign heat_any = |heat_sel;

  assert_heat_onehot0_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(heat_sel));

  assert_dir_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    field_en |-> $stable(field_dir));

  assert_field_heated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(field_en) |-> heat_any);

  assert_cool_under_field_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(heat_any) |-> field_en);

  assert_done_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |-> (!heat_any && !field_en));

  assert_release_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(field_en) |-> wr_done);

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

  assert_ack_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |=> !wr_ack);

  assert_ack_from_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ack |-> $past(!busy));

endmodule

bind twr_write_seq twr_write_seq_chk #(.NUM_CELLS(NUM_CELLS)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .heat_sel  (heat_sel),
  .field_en  (field_en),
  .field_dir (field_dir),
  .wr_ack    (wr_ack),
  .wr_done   (wr_done),
  .busy      (busy)
);

// File: tb/twr_write_seq_tb_top.sv
module twr_write_seq_tb_top;

  localparam int N     = 6;
  localparam int AW    = 3;
  localparam int H     = 1;
  localparam int F     = 1;
  localparam int C     = 2;
  localparam int PER   = 8000;
  localparam int BUDG  = 35000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_req = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic          wr_data = 1'b0;
  logic          wr_ack;
  logic [N-1:0]  heat_sel;
  logic          field_en;
  logic          field_dir;
  logic          wr_done;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  twr_write_seq #(
    .NUM_CELLS(N), .HEAT_CYC(H), .FIELD_CYC(F), .COOL_CYC(C),
    .CLK_PERIOD_PS(PER), .BUDGET_PS(BUDG)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_req(wr_req), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_ack(wr_ack), .heat_sel(heat_sel),
    .field_en(field_en), .field_dir(field_dir), .wr_done(wr_done)
  );

  // Behavioural reference: elapsed cycles since acceptance
  bit m_busy = 0;
  bit m_valid = 0;
  int m_t = 0;
  int m_end = 0;
  int m_addr = 0;
  bit m_dir = 0;
  bit e_ack = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_dir = 0; e_ack = 0; m_t = 0;
    end else begin
      e_ack = 0;
      if (!m_busy && wr_req) begin
        m_busy  = 1;
        m_t     = 0;
        m_addr  = int'(wr_addr);
        m_valid = (m_addr < N);
        if (m_valid) m_dir = wr_data;
        m_end   = m_valid ? (H + F + C) : 0;
        e_ack   = 1;
      end else if (m_busy) begin
        m_t++;
        if (m_t > m_end) m_busy = 0;
      end
    end
  end

  function automatic logic [N-1:0] exp_heat();
    if (m_busy && m_valid && m_t < H + F) return N'(1) << m_addr;
    return '0;
  endfunction

  function automatic bit exp_field();
    return m_busy && m_valid && m_t >= H && m_t < H + F + C;
  endfunction

  function automatic bit exp_done();
    return m_busy && m_t == m_end;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  bit cmp_on = 0;
  bit prev_field = 0;

  always @(negedge clk) begin
    if (cmp_on) begin
      string tg;
      tg = (m_busy && !m_valid) ? "R8" : "R4";
      check(heat_sel == exp_heat(), tg, int'(heat_sel), int'(exp_heat()));
      tg = (m_busy && !m_valid) ? "R8" : "R2";
      check(field_en == exp_field(), tg, field_en, exp_field());
      tg = (m_busy && !m_valid) ? "R8" : "R3";
      check(field_dir == m_dir, tg, field_dir, m_dir);
      check(wr_ack == e_ack, "R6", wr_ack, e_ack);
      check(wr_done == exp_done(), "R7", wr_done, exp_done());
      if (field_en && !prev_field)
        check(heat_sel != '0, "R5", int'(heat_sel), 1);
      prev_field = field_en;
    end
  end

  task automatic do_write(input int a, input bit d);
    @(negedge clk);
    wr_req  = 1'b1;
    wr_addr = AW'(a);
    wr_data = d;
    do @(negedge clk); while (!wr_ack);
    wr_req = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset
    check(heat_sel == '0 && !field_en && !field_dir && !wr_ack && !wr_done,
          "R1", int'(heat_sel), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(heat_sel == '0 && !field_en && !field_dir && !wr_ack && !wr_done,
          "R1", int'(heat_sel), 0);
    cmp_on = 1;
    // R9: configured span inside the budget
    check((H + F + C) * PER <= BUDG, "R9", (H + F + C) * PER, BUDG);

    do_write(0, 1'b1); idle(8);
    do_write(5, 1'b0); idle(8);
    do_write(3, 1'b1); idle(8);
    do_write(6, 1'b0); idle(4);       // R8 out of range, dir keeps 1
    do_write(7, 1'b0); idle(4);
    do_write(2, 1'b0);                // back-to-back, R6 held request
    do_write(4, 1'b1);
    do_write(1, 1'b0);
    do_write(7, 1'b1);                // out of range right after busy
    do_write(5, 1'b1); idle(8);
    for (int i = 0; i < N; i++) begin
      do_write(i, i[0]);
      idle(i % 3);
    end
    idle(10);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule